// File: doc/BRIEF.md
# Three-Lane Word Aligner

This block takes three parallel 28-bit lane words, each produced by its own deserializer in its own lane clock domain, and turns them into one coherent stream in the system clock domain. The lane clocks may differ in phase and are not related to one another or to the system clock. Each lane is written into its own dual-clock queue with Gray-coded pointers. The system side releases one word from every queue in the same cycle, and only when all three hold data. The three words are joined into an 84-bit link word. A mapping fixed at elaboration extracts four synchronization bits and 80 data bits from it and presents them on an AXI4-Stream master port.

Start-up alignment works by flushing all three queues together and then waiting until every queue has received its first word. Losing lockstep is a fatal condition. This happens when a queue overflows, or when some queues stay empty while others hold data for longer than a set window. Either case raises a sticky error flag, drops the locked indication and freezes the release of words until a soft reset. The soft reset flushes the queues and the output register and starts a new alignment.

Back-pressure: the output holds tdata, tuser and tvalid stable while tvalid is high and tready is low. While the output slot is blocked, words stay in the lane queues. The queues have no back-pressure path to the lanes, so a stall longer than the queue depth ends in an overflow error.

Top module: `tri_lane_aligner`

## Requirements
- R1: After reset, m_tvalid, locked, err_overflow and err_lockstep are all 0.
- R2: No word is released until all three queues hold at least one word. While any queue is empty, m_tvalid stays 0 and no word is lost.
- R3: The link word is {lane2, lane1, lane0} (bit 0 = lane0 bit 0). Spare is bit 26, line-valid is bit 27, frame-valid is bit 55 and data-valid is bit 83. The other 80 bits fill m_tdata from bit 0 upward in ascending link-bit order. m_tuser carries [0] frame-valid, [1] line-valid, [2] data-valid, [3] spare.
- R4: m_tvalid is 1 only for words whose data-valid bit is 1. Words with data-valid 0 are consumed without appearing on the output.
- R5: Every word with data-valid 1 written on all three lanes appears exactly once and in write order, with any lane phase and any tready pattern that does not overflow a queue.
- R6: A write to a full queue (DEPTH = 16 entries) sets the sticky err_overflow, clears locked and stops further release of words.
- R7: If some but not all queues are empty for SKEW_LIMIT = 8 consecutive system cycles, the sticky err_lockstep is set, locked is cleared and release stops.
- R8: A one-cycle soft_reset clears both error flags, empties all queues and the output register, and re-aligns. Words written afterwards stream correctly again.
- R9: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tuser hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | 3 | Per-lane word clock |
| lane_rst_n | input | 3 | Per-lane active-low reset, asynchronous assert |
| lane_we | input | 3 | Per-lane word strobe, one word per lane clock |
| lane_word | input | 84 | Lane words, lane k at bits [28k+27:28k] |
| clk | input | 1 | System clock |
| rst_n | input | 1 | System active-low reset |
| soft_reset | input | 1 | One-cycle request to clear errors, flush and re-align |
| m_tdata | output | 80 | Stream data |
| m_tuser | output | 4 | Stream sync bits (frame, line, data-valid, spare) |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| locked | output | 1 | All three queues aligned and words flowing |
| err_overflow | output | 1 | Sticky queue overflow flag |
| err_lockstep | output | 1 | Sticky loss-of-lockstep flag |

## Verification
The hardest state to reach from the ports is a loss of lockstep without any overflow. Three real lanes always write together, so the bench drives only two of them for a short burst. Those two queues fill while the third stays empty, and the skew window runs out with no word released. The overflow error is reached by holding tready low through a burst of data-valid words. Each error is then followed by a soft reset and a fresh stream, which shows that alignment recovers.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int LANES  = 3;
  localparam int SYNC_N = 4;

  typedef enum logic [2:0] {
    ST_FLUSH   = 3'd0,
    ST_RELEASE = 3'd1,
    ST_ALIGN   = 3'd2,
    ST_RUN     = 3'd3,
    ST_HALT    = 3'd4
  } ctrl_state_t;

  // packed order gives tuser[0]=frame, [1]=line, [2]=data-valid, [3]=spare
  typedef struct packed {
    logic spare;
    logic dval;
    logic lval;
    logic fval;
  } sync_t;
endpackage

// File: rtl/tla_sync.sv
module tla_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tla_lane_fifo.sv
module tla_lane_fifo #(
  parameter int W  = 28,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         flush_req,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovf,
  output logic         flush_ack
);
  logic [W-1:0] mem [DEPTH];

  // write domain
  logic [AW:0] wbin, wgray, rgray_w, wbin_nx;
  logic        wflush, full, ovf_w;

  tla_sync #(.W(1)) u_flush_w (
    .clk(wclk), .rst_n(wrst_n), .d(flush_req), .q(wflush));

  logic [AW:0] rgray;
  tla_sync #(.W(AW+1)) u_rptr_w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

  assign full    = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_w <= 1'b0;
    end else if (wflush) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_w <= 1'b0;
    end else if (we) begin
      if (full) begin
        ovf_w <= 1'b1;
      end else begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst_n && !wflush && we && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  // read domain
  logic [AW:0] rbin, rbin_nx, wgray_r;

  tla_sync #(.W(AW+1)) u_wptr_r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));
  tla_sync #(.W(1)) u_ack_r (
    .clk(rclk), .rst_n(rrst_n), .d(wflush), .q(flush_ack));
  tla_sync #(.W(1)) u_ovf_r (
    .clk(rclk), .rst_n(rrst_n), .d(ovf_w), .q(ovf));

  assign empty   = (rgray == wgray_r);
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (flush_req) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop && !empty) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/tla_mapper.sv
module tla_mapper import tla_pkg::*; #(
  parameter int RAW_W     = 84,
  parameter int POS_SPARE = 26,
  parameter int POS_LVAL  = 27,
  parameter int POS_FVAL  = 55,
  parameter int POS_DVAL  = 83,
  localparam int DATA_W   = RAW_W - SYNC_N
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [DATA_W-1:0] data,
  output sync_t             sync
);
  function automatic int src_bit(input int n);
    int  seen;
    int  pick;
    bit  found;
    seen  = 0;
    pick  = 0;
    found = 1'b0;
    for (int k = 0; k < RAW_W; k++) begin
      if (k != POS_SPARE && k != POS_LVAL && k != POS_FVAL && k != POS_DVAL) begin
        if (!found && seen == n) begin
          pick  = k;
          found = 1'b1;
        end
        seen++;
      end
    end
    return pick;
  endfunction

  for (genvar n = 0; n < DATA_W; n++) begin : g_data
    localparam int SRC = src_bit(n);
    assign data[n] = raw[SRC];
  end

  assign sync.fval  = raw[POS_FVAL];
  assign sync.lval  = raw[POS_LVAL];
  assign sync.dval  = raw[POS_DVAL];
  assign sync.spare = raw[POS_SPARE];
endmodule

// File: rtl/tla_ctrl.sv
module tla_ctrl import tla_pkg::*; #(
  parameter int N          = 3,
  parameter int SKEW_LIMIT = 8,
  localparam int CW        = $clog2(SKEW_LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_reset,
  input  logic [N-1:0] empty,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] ack,
  input  logic         slot_free,
  output logic         flush_req,
  output logic         pop,
  output logic         locked,
  output logic         err_ovf,
  output logic         err_lock
);
  ctrl_state_t st, st_nx;
  logic [CW-1:0] skew_cnt;
  logic all_ready, split, active, skew_trip, ovf_hit;

  assign all_ready = ~|empty;
  assign split     = (|empty) && !(&empty);
  assign active    = (st == ST_ALIGN) || (st == ST_RUN);
  assign skew_trip = active && split && (skew_cnt == CW'(SKEW_LIMIT - 1));
  assign ovf_hit   = active && (|ovf);

  always_comb begin
    st_nx = st;
    if (soft_reset) begin
      st_nx = ST_FLUSH;
    end else begin
      case (st)
        ST_FLUSH:   if (&ack) st_nx = ST_RELEASE;
        ST_RELEASE: if (~|ack) st_nx = ST_ALIGN;
        ST_ALIGN: begin
          if (ovf_hit || skew_trip) st_nx = ST_HALT;
          else if (all_ready)       st_nx = ST_RUN;
        end
        ST_RUN:     if (ovf_hit || skew_trip) st_nx = ST_HALT;
        default:    st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_FLUSH;
      skew_cnt <= '0;
      err_ovf  <= 1'b0;
      err_lock <= 1'b0;
    end else begin
      st <= st_nx;
      if (active && split && !skew_trip) skew_cnt <= skew_cnt + 1'b1;
      else                               skew_cnt <= '0;
      if (soft_reset) begin
        err_ovf  <= 1'b0;
        err_lock <= 1'b0;
      end else begin
        if (ovf_hit)   err_ovf  <= 1'b1;
        if (skew_trip) err_lock <= 1'b1;
      end
    end
  end

  assign flush_req = (st == ST_FLUSH);
  assign locked    = (st == ST_RUN);
  assign pop       = (st == ST_RUN) && all_ready && slot_free && !(|ovf) && !soft_reset;
endmodule

// File: rtl/tri_lane_aligner.sv
module tri_lane_aligner import tla_pkg::*; #(
  parameter int LANE_W     = 28,
  parameter int DEPTH      = 16,
  parameter int SKEW_LIMIT = 8,
  parameter int POS_SPARE  = 26,
  parameter int POS_LVAL   = 27,
  parameter int POS_FVAL   = 55,
  parameter int POS_DVAL   = 83,
  localparam int RAW_W     = LANES * LANE_W,
  localparam int DATA_W    = RAW_W - SYNC_N
) (
  input  logic [LANES-1:0]  lane_clk,
  input  logic [LANES-1:0]  lane_rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [RAW_W-1:0]  lane_word,
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  output logic [DATA_W-1:0] m_tdata,
  output logic [SYNC_N-1:0] m_tuser,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              locked,
  output logic              err_overflow,
  output logic              err_lockstep
);
  localparam int AW = $clog2(DEPTH);

  logic [RAW_W-1:0] raw_word;
  logic [LANES-1:0] q_empty, q_ovf, q_ack;
  logic             flush_req, pop, slot_free;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tla_lane_fifo #(.W(LANE_W), .AW(AW)) u_q (
      .wclk      (lane_clk[g]),
      .wrst_n    (lane_rst_n[g]),
      .we        (lane_we[g]),
      .wdata     (lane_word[g*LANE_W +: LANE_W]),
      .rclk      (clk),
      .rrst_n    (rst_n),
      .flush_req (flush_req),
      .pop       (pop),
      .rdata     (raw_word[g*LANE_W +: LANE_W]),
      .empty     (q_empty[g]),
      .ovf       (q_ovf[g]),
      .flush_ack (q_ack[g])
    );
  end

  tla_ctrl #(.N(LANES), .SKEW_LIMIT(SKEW_LIMIT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_reset(soft_reset),
    .empty     (q_empty),
    .ovf       (q_ovf),
    .ack       (q_ack),
    .slot_free (slot_free),
    .flush_req (flush_req),
    .pop       (pop),
    .locked    (locked),
    .err_ovf   (err_overflow),
    .err_lock  (err_lockstep)
  );

  logic [DATA_W-1:0] map_data;
  sync_t             map_sync;

  tla_mapper #(
    .RAW_W(RAW_W), .POS_SPARE(POS_SPARE), .POS_LVAL(POS_LVAL),
    .POS_FVAL(POS_FVAL), .POS_DVAL(POS_DVAL)
  ) u_map (
    .raw (raw_word),
    .data(map_data),
    .sync(map_sync)
  );

  // output register: one slot, refilled on the cycle it is consumed
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  sync_t             out_sync;

  assign slot_free = !out_valid || m_tready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sync  <= '0;
    end else if (flush_req) begin
      out_valid <= 1'b0;
    end else if (pop) begin
      out_valid <= map_sync.dval;
      out_data  <= map_data;
      out_sync  <= map_sync;
    end else if (m_tready) begin
      out_valid <= 1'b0;
    end
  end

  assign m_tvalid = out_valid;
  assign m_tdata  = out_data;
  assign m_tuser  = out_sync;
endmodule

// File: rtl/tri_lane_aligner_checker.sv
module tri_lane_aligner_checker #(
  parameter int DATA_W = 80,
  parameter int USER_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_reset,
  input logic              flush_req,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [USER_W-1:0] m_tuser,
  input logic              locked,
  input logic              err_overflow,
  input logic              err_lockstep
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || flush_req)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser));

  p_tvalid_dval_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tuser[2]);

  p_release_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> $past(locked));

  p_sticky_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow && !soft_reset |=> err_overflow);

  p_ovf_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> !locked);

  p_sticky_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_lockstep && !soft_reset |=> err_lockstep);

  p_lock_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_lockstep |-> !locked);

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !m_tvalid && !locked);
endmodule

bind tri_lane_aligner tri_lane_aligner_checker #(.DATA_W(DATA_W), .USER_W(SYNC_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_reset  (soft_reset),
  .flush_req   (flush_req),
  .m_tvalid    (m_tvalid),
  .m_tready    (m_tready),
  .m_tdata     (m_tdata),
  .m_tuser     (m_tuser),
  .locked      (locked),
  .err_overflow(err_overflow),
  .err_lockstep(err_lockstep)
);

// File: tb/tri_lane_aligner_test.sv
`timescale 1ns/10ps
module tri_lane_aligner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_reset = 1'b0;
  logic lclk0 = 1'b0, lclk1 = 1'b0, lclk2 = 1'b0;
  logic we0 = 1'b0, we1 = 1'b0, we2 = 1'b0;
  logic [27:0] w0 = '0, w1 = '0, w2 = '0;
  logic [79:0] m_tdata;
  logic [3:0]  m_tuser;
  logic m_tvalid, m_tready, locked, err_overflow, err_lockstep;

  int total = 0;
  int bad = 0;
  int tv_seen = 0;
  bit sb_on = 1'b0;
  int ready_mode = 1;
  logic [83:0] exp_q [$];
  logic [4:0] lfsr = 5'h1b;

  tri_lane_aligner uut (
    .lane_clk    ({lclk2, lclk1, lclk0}),
    .lane_rst_n  ({3{rst_n}}),
    .lane_we     ({we2, we1, we0}),
    .lane_word   ({w2, w1, w0}),
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_reset  (soft_reset),
    .m_tdata     (m_tdata),
    .m_tuser     (m_tuser),
    .m_tvalid    (m_tvalid),
    .m_tready    (m_tready),
    .locked      (locked),
    .err_overflow(err_overflow),
    .err_lockstep(err_lockstep)
  );

  always #2 clk = ~clk;
  initial forever #6 lclk0 = ~lclk0;
  initial begin #2.3; forever #6 lclk1 = ~lclk1; end
  initial begin #4.7; forever #6 lclk2 = ~lclk2; end

  // ready pattern, driven after the edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    case (ready_mode)
      0:       m_tready = 1'b0;
      2:       m_tready = lfsr[0];
      default: m_tready = 1'b1;
    endcase
  end

  task automatic check(input bit ok, input string what, input logic [83:0] act, input logic [83:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // expected word: {tuser[3:0], tdata[79:0]}
  function automatic logic [83:0] gen_exp(input int i, input int salt, input bit fdv);
    logic [79:0] d;
    logic [3:0]  s;
    d = {16'(i) ^ 16'(salt), 32'(i) * 32'h9E3779B1, 32'(i) * 32'h01000193 + 32'(salt)};
    s = 4'(i + salt);
    if (fdv) s[2] = 1'b1;
    return {s, d};
  endfunction

  // link word layout from R3: spare@26, line@27, frame@55, data-valid@83
  function automatic logic [83:0] pack(input logic [83:0] e);
    logic [83:0] r;
    int j;
    j = 0;
    r = '0;
    for (int k = 0; k < 84; k++) begin
      case (k)
        26: r[k] = e[83];
        27: r[k] = e[81];
        55: r[k] = e[80];
        83: r[k] = e[82];
        default: begin r[k] = e[j]; j++; end
      endcase
    end
    return r;
  endfunction

  task automatic lane_edge(input int k);
    case (k)
      0: @(posedge lclk0);
      1: @(posedge lclk1);
      default: @(posedge lclk2);
    endcase
    #1;
  endtask

  task automatic lane_put(input int k, input bit en, input logic [27:0] v);
    case (k)
      0: begin we0 = en; w0 = v; end
      1: begin we1 = en; w1 = v; end
      default: begin we2 = en; w2 = v; end
    endcase
  endtask

  task automatic lane_run(input int k, input int n, input int salt, input bit fdv, input bit en);
    for (int i = 0; i < n; i++) begin
      logic [83:0] r;
      r = pack(gen_exp(i, salt, fdv));
      lane_edge(k);
      lane_put(k, en && (i % 7 != 3), r[k*28 +: 28]);
    end
    lane_edge(k);
    lane_put(k, 1'b0, '0);
  endtask

  task automatic drive_all(input int n, input int salt, input bit fdv, input logic [2:0] mask, input bit push);
    if (push) begin
      for (int i = 0; i < n; i++) begin
        logic [83:0] e;
        e = gen_exp(i, salt, fdv);
        if (i % 7 != 3 && e[82]) exp_q.push_back(e);
      end
    end
    fork
      lane_run(0, n, salt, fdv, mask[0]);
      lane_run(1, n, salt, fdv, mask[1]);
      lane_run(2, n, salt, fdv, mask[2]);
    join
  endtask

  task automatic wait_drain(input string tag);
    for (int c = 0; c < 3000 && exp_q.size() != 0; c++) @(posedge clk);
    repeat (8) @(posedge clk);
    check(exp_q.size() == 0, tag, 84'(exp_q.size()), 84'd0);
  endtask

  task automatic pulse_soft_reset();
    @(posedge clk); #1 soft_reset = 1'b1;
    @(posedge clk); #1 soft_reset = 1'b0;
    repeat (60) @(posedge clk);
  endtask

  // output monitor, sampled between edges
  logic        hold_pend = 1'b0;
  logic [83:0] hold_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_tvalid) tv_seen++;
      if (m_tvalid && m_tready) begin
        check(m_tuser[2] == 1'b1, "R4 tvalid with data-valid low", 84'(m_tuser), 84'h4);
        if (sb_on) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected beat", {m_tuser, m_tdata}, '0);
          end else begin
            logic [83:0] e;
            e = exp_q.pop_front();
            check({m_tuser, m_tdata} == e, "R3 R5 beat content/order", {m_tuser, m_tdata}, e);
          end
        end
      end
      if (hold_pend && sb_on)
        check(m_tvalid && ({m_tuser, m_tdata} == hold_val), "R9 hold under back-pressure",
              {m_tuser, m_tdata}, hold_val);
      hold_pend = m_tvalid && !m_tready;
      hold_val  = {m_tuser, m_tdata};
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_tready = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    check(!m_tvalid && !locked && !err_overflow && !err_lockstep, "R1 in reset",
          {80'd0, m_tvalid, locked, err_overflow, err_lockstep}, '0);
    rst_n = 1'b1;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid && !locked && !err_overflow && !err_lockstep, "R1 after reset",
          {80'd0, m_tvalid, locked, err_overflow, err_lockstep}, '0);
    check(!locked, "R2 not locked before any lane word", 84'(locked), 84'd0);

    // steady stream, tready high
    sb_on = 1'b1;
    ready_mode = 1;
    drive_all(64, 5, 1'b0, 3'b111, 1'b1);
    wait_drain("R5 all words delivered, ready high");
    check(locked && !err_overflow && !err_lockstep, "R2 locked after alignment",
          {81'd0, locked, err_overflow, err_lockstep}, 84'h4);

    // sweep under random back-pressure, several salts
    ready_mode = 2;
    for (int s = 0; s < 4; s++) begin
      drive_all(96, 17 * s + 3, 1'b0, 3'b111, 1'b1);
      wait_drain("R5 all words delivered under back-pressure");
    end
    check(!err_overflow && !err_lockstep, "R5 no error under back-pressure",
          {82'd0, err_overflow, err_lockstep}, '0);

    // overflow: stall output through a long data-valid burst
    sb_on = 1'b0;
    ready_mode = 0;
    drive_all(40, 9, 1'b1, 3'b111, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(err_overflow && !err_lockstep && !locked, "R6 overflow sets sticky error",
          {81'd0, err_overflow, err_lockstep, locked}, 84'h4);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(err_overflow && !locked, "R6 overflow error stays", {82'd0, err_overflow, locked}, 84'h2);

    // recover
    ready_mode = 1;
    pulse_soft_reset();
    @(negedge clk);
    check(!err_overflow && !err_lockstep && !m_tvalid, "R8 soft reset clears state",
          {81'd0, err_overflow, err_lockstep, m_tvalid}, '0);
    exp_q.delete();
    sb_on = 1'b1;
    drive_all(48, 41, 1'b0, 3'b111, 1'b1);
    wait_drain("R8 stream after soft reset");
    check(locked, "R8 re-locked", 84'(locked), 84'd1);

    // loss of lockstep: lane 2 silent
    sb_on = 1'b0;
    tv_seen = 0;
    drive_all(10, 77, 1'b1, 3'b011, 1'b0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(err_lockstep && !err_overflow && !locked, "R7 skew sets sticky error",
          {81'd0, err_lockstep, err_overflow, locked}, 84'h4);
    check(tv_seen == 0, "R2 nothing released with one queue empty", 84'(tv_seen), 84'd0);

    pulse_soft_reset();
    @(negedge clk);
    check(!err_lockstep && !err_overflow, "R8 soft reset clears skew error",
          {82'd0, err_lockstep, err_overflow}, '0);
    exp_q.delete();
    sb_on = 1'b1;
    ready_mode = 2;
    drive_all(64, 123, 1'b0, 3'b111, 1'b1);
    wait_drain("R8 stream after skew recovery");
    check(!err_lockstep && !err_overflow, "R7 no false skew error", {82'd0, err_lockstep, err_overflow}, '0);

    finish_run();
  end
endmodule